// File: doc/BRIEF.md
# Function-Select ALU with Status Flags

This block is a combinational arithmetic and logic unit for a datapath of configurable width, 16 bits by default. Two operands and a 3-bit function code go in; the result comes out in the same cycle. The unit supports addition, subtraction, decrement, bitwise AND, OR and NOT. Alongside the result it produces a carry/borrow bit, a zero indicator and an unsigned magnitude compare of the operands. It also derives parity, sign and signed overflow, so that a surrounding flag register can load them directly.

A flag stage is selected by a parameter. When it is enabled, the six flags are captured into a register on any clock edge where the load enable is high. When it is disabled, the flag bus simply follows the combinational flags. Instruction decoding that produces the function code sits outside this block.

Top module: `fn_alu`

## Requirements
- R1: Function code 000 gives Y = (A + B) mod 2^W, and carry is the carry out of the W-bit sum.
- R2: Function code 001 gives Y = (A - B) mod 2^W, and carry is 1 exactly when A < B unsigned (a borrow).
- R3: Function code 010 gives Y = (A - 1) mod 2^W, and carry is 1 exactly when A is zero (a borrow).
- R4: Function code 011 gives A AND B and code 100 gives A OR B, with carry 0.
- R5: Function code 101 gives the bitwise complement of A, with carry 0.
- R6: Function codes 110 and 111 give Y = 0 with carry 0.
- R7: The zero output is 1 exactly when every bit of Y is 0.
- R8: The gt output is 1 exactly when A > B as unsigned numbers, whatever the function code.
- R9: Parity is 1 when Y[7:0] holds an even number of ones (all of Y when W < 8). Sign equals the most significant bit of Y.
- R10: Overflow is 1 for codes 000, 001 and 010 when the true two's-complement result (A+B, A-B or A-1) lies outside the signed W-bit range. It is 0 for every other code.
- R11: With the flag stage present, flag_q is cleared by the asynchronous active-low reset. It loads {overflow, sign, parity, gt, zero, carry} (bit 5 down to bit 0) on a rising clock edge when flag_en is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag stage |
| rst_n | input | 1 | Asynchronous active-low reset of the flag stage |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| fsel | input | 3 | Function code |
| flag_en | input | 1 | Load enable for the flag stage |
| y | output | WIDTH | Result |
| carry | output | 1 | Carry out, or borrow for subtract and decrement |
| zero | output | 1 | Result is all zeros |
| gt | output | 1 | op_a greater than op_b, unsigned |
| parity | output | 1 | Even number of ones in the low byte of the result |
| sign | output | 1 | Most significant bit of the result |
| ovf | output | 1 | Signed overflow of add, subtract or decrement |
| flag_q | output | 6 | Flag stage {ovf, sign, parity, gt, zero, carry} |

## Verification
The bench builds the block with WIDTH = 16 and the flag stage present, which is the width where the boundaries fit in a few directed vectors: 0x7FFF, 0x8000, 0xFFFF and zero. The same build reaches the load-enable and hold paths of the register and its reset. Directed vectors put carry, borrow and overflow at their exact edges, including the decrement of zero and of the most negative value. A pseudo-random sweep then covers all eight function codes, so that the compare output is seen under every code.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_DEC  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_NOT  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic parity;
    logic gt;
    logic zero;
    logic carry;
  } alu_flags_t;

  localparam int FLAG_BITS = $bits(alu_flags_t);

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_DEC);
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_NOT);
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] res,
  output logic             cb,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  // Full adder of the W-bit operands plus carry-in; returns {cout, sum}.
  function automatic logic [WIDTH:0] add_ext(logic [WIDTH-1:0] x,
                                             logic [WIDTH-1:0] z,
                                             logic cin);
    return {1'b0, x} + {1'b0, z} + {{WIDTH{1'b0}}, cin};
  endfunction

  // Signed overflow from operand and result signs.
  function automatic logic sgn_ovf(logic sx, logic sz, logic sr);
    return (sx == sz) && (sr != sx);
  endfunction

  logic [WIDTH-1:0] opnd2;
  logic             cin;
  logic [WIDTH:0]   sum_ext;
  logic             cout_raw;
  logic             is_borrow_op;
  logic             arith_act;

  always_comb begin
    unique case (op)
      OP_SUB:  begin opnd2 = ~b;              cin = 1'b1; end
      OP_DEC:  begin opnd2 = {WIDTH{1'b1}};   cin = 1'b0; end
      default: begin opnd2 = b;               cin = 1'b0; end
    endcase
  end

  assign sum_ext      = add_ext(a, opnd2, cin);
  assign cout_raw     = sum_ext[WIDTH];
  assign res          = sum_ext[WIDTH-1:0];
  assign is_borrow_op = (op == OP_SUB) || (op == OP_DEC);
  assign arith_act    = op_is_arith(op);

  always_comb begin
    if (!arith_act) begin
      cb  = 1'b0;
      ovf = 1'b0;
    end else begin
      cb  = is_borrow_op ? ~cout_raw : cout_raw;
      ovf = sgn_ovf(a[MSB], opnd2[MSB], res[MSB]);
    end
  end

  // R1: sum and carry against a widened addition
  p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |-> ({cb, res} == ({1'b0, a} + {1'b0, b})));

  // R2: borrow tracks the unsigned order of the operands
  p_sub_borrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |-> (cb == (a < b)));

  // R3: decrement borrows only from zero
  p_dec_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC) |-> ((cb == (a == '0)) && ((res + 1'b1) == a)));

  // R10: overflow confined to arithmetic codes
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arith_act |-> !ovf);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end

  // R5: complement shares no set bit with A and covers all others
  p_not_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOT) |-> (((res & a) == '0) && ((res | a) == '1)));

  // R4: AND result is a subset of both operands, OR a superset
  p_and_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_AND) |-> (((res & ~a) == '0) && ((res & ~b) == '0))) and
    ((op == OP_OR)  |-> (((a & ~res) == '0) && ((b & ~res) == '0))));

  // R6: reserved codes yield zero
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_RSV6) || (op == OP_RSV7)) |-> ($countones(res) == 0));

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] y,
  input  logic             cb,
  input  logic             ovf,
  output alu_flags_t       flags
);

  localparam int PAR_W = (WIDTH < 8) ? WIDTH : 8;

  function automatic logic even_ones(logic [PAR_W-1:0] v);
    return ~(^v);
  endfunction

  logic [PAR_W-1:0] par_bits;
  assign par_bits = y[PAR_W-1:0];

  always_comb begin
    flags.carry  = cb;
    flags.zero   = (y == '0);
    flags.gt     = (a > b);
    flags.parity = even_ones(par_bits);
    flags.sign   = y[WIDTH-1];
    flags.ovf    = ovf;
  end

  // R7: zero agrees with the population count of the result
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flags.zero == ($countones(y) == 0));

  // R8: gt excludes equality and the reverse order
  p_gt_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags.gt |-> ((a != b) && !(b > a)));

  // R9: parity from a bit count of the low byte
  p_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags.parity == ($countones(par_bits) % 2 == 0));

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
#(
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  alu_flags_t d,
  output alu_flags_t q
);

  generate
    if (REG_FLAGS) begin : g_reg
      alu_flags_t q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_r <= '0;
        else if (en) q_r <= d;
      end
      assign q = q_r;

      // R11: load on enable
      p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |-> (q == $past(d)));

      // R11: hold without enable
      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> $stable(q));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/fn_alu.sv
module fn_alu
  import alu_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       fsel,
  input  logic             flag_en,
  output logic [WIDTH-1:0] y,
  output logic             carry,
  output logic             zero,
  output logic             gt,
  output logic             parity,
  output logic             sign,
  output logic             ovf,
  output logic [5:0]       flag_q
);

  alu_op_e          op;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_cb;
  logic             arith_ovf;
  logic             sel_arith;
  alu_flags_t       flags_c;
  alu_flags_t       flags_r;

  assign op        = alu_op_e'(fsel);
  assign sel_arith = op_is_arith(op);

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .clk(clk), .rst_n(rst_n), .a(op_a), .b(op_b), .op(op),
    .res(arith_res), .cb(arith_cb), .ovf(arith_ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .clk(clk), .rst_n(rst_n), .a(op_a), .b(op_b), .op(op),
    .res(logic_res)
  );

  assign y = sel_arith ? arith_res : logic_res;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .a(op_a), .b(op_b), .y(y),
    .cb(arith_cb), .ovf(arith_ovf), .flags(flags_c)
  );

  alu_flag_reg #(.REG_FLAGS(REG_FLAGS)) u_freg (
    .clk(clk), .rst_n(rst_n), .en(flag_en), .d(flags_c), .q(flags_r)
  );

  assign carry  = flags_c.carry;
  assign zero   = flags_c.zero;
  assign gt     = flags_c.gt;
  assign parity = flags_c.parity;
  assign sign   = flags_c.sign;
  assign ovf    = flags_c.ovf;
  assign flag_q = flags_r;

  // R4: non-arithmetic codes never raise carry (R5, R6 share this)
  p_logic_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_arith |-> !carry);

  // R9: sign follows the result MSB at the port
  p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sign == y[WIDTH-1]);

endmodule

// File: tb/fn_alu_bench.sv
`timescale 1ns/1ps
module fn_alu_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2:0]   fsel = '0;
  logic         flag_en = 1'b0;
  logic [W-1:0] y;
  logic         carry, zero, gt, parity, sign, ovf;
  logic [5:0]   flag_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fn_alu #(.WIDTH(W), .REG_FLAGS(1'b1)) u_fn_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fsel(fsel),
    .flag_en(flag_en), .y(y), .carry(carry), .zero(zero), .gt(gt),
    .parity(parity), .sign(sign), .ovf(ovf), .flag_q(flag_q)
  );

  typedef struct {
    logic [W-1:0] a, b;
    logic [2:0]   f;
    logic         en;
    logic [W-1:0] ey;
    logic [5:0]   efl;  // {ovf, sign, parity, gt, zero, carry}
  } item_t;

  item_t sb_q[$];
  item_t cur;
  logic [5:0] exp_fq = '0;

  // Reference model in integer arithmetic.
  function automatic item_t model(logic [W-1:0] a, logic [W-1:0] b,
                                  logic [2:0] f, logic en);
    item_t it;
    int ia = int'(a), ib = int'(b);
    int sa = int'($signed(a)), sb = int'($signed(b));
    int wide = 0, sres = 0, ones = 0;
    logic c = 1'b0, v = 1'b0;
    it.a = a; it.b = b; it.f = f; it.en = en;
    case (f)
      3'd0: begin wide = ia + ib; c = (wide >= 65536); sres = sa + sb; v = 1'b1; end
      3'd1: begin wide = ia - ib; c = (ia < ib); sres = sa - sb; v = 1'b1; end
      3'd2: begin wide = ia - 1;  c = (ia == 0); sres = sa - 1;  v = 1'b1; end
      3'd3: wide = int'(a & b);
      3'd4: wide = int'(a | b);
      3'd5: wide = int'(~a);
      default: wide = 0;
    endcase
    it.ey = W'(wide & 32'hFFFF);
    for (int i = 0; i < 8; i++) ones += int'(it.ey[i]);
    it.efl[0] = c;
    it.efl[1] = (it.ey == 0);
    it.efl[2] = (ia > ib);
    it.efl[3] = (ones % 2 == 0);
    it.efl[4] = it.ey[W-1];
    it.efl[5] = v && (sres > 32767 || sres < -32768);
    return it;
  endfunction

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (a=%h b=%h f=%0d)",
               req, what, act, exp, cur.a, cur.b, cur.f);
    end
  endtask

  // Driver: apply one vector and queue its expectation.
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f, logic en);
    @(negedge clk);
    op_a = a; op_b = b; fsel = f; flag_en = en;
    sb_q.push_back(model(a, b, f, en));
  endtask

  // Monitor: compare after inputs settle each cycle.
  initial begin
    cur = model('0, '0, 3'd0, 1'b0);
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      chk("R11", W'(flag_q), W'(exp_fq), "flag_q");
      if (sb_q.size() > 0) cur = sb_q.pop_front();
      chk(req_of(cur.f), y, cur.ey, "y");
      chk(req_of(cur.f), W'(carry), W'(cur.efl[0]), "carry");
      chk("R7", W'(zero), W'(cur.efl[1]), "zero");
      chk("R8", W'(gt), W'(cur.efl[2]), "gt");
      chk("R9", W'(parity), W'(cur.efl[3]), "parity");
      chk("R9", W'(sign), W'(cur.efl[4]), "sign");
      chk("R10", W'(ovf), W'(cur.efl[5]), "ovf");
      if (cur.en) exp_fq = cur.efl;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1D2C_3B4A;
    // R11: reset clears the flag stage even with load enable high
    op_a = 16'hFFFF; op_b = 16'h0001; fsel = 3'd0; flag_en = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R11", W'(flag_q), '0, "flag_q in reset");
    @(negedge clk);
    op_a = '0; op_b = '0; fsel = 3'd0; flag_en = 1'b0;
    rst_n = 1'b1;

    // R1 carry and overflow edges
    drive(16'hFFFF, 16'h0001, 3'd0, 1'b1);
    drive(16'h7FFF, 16'h0001, 3'd0, 1'b0);
    drive(16'h8000, 16'h8000, 3'd0, 1'b1);
    drive(16'h1234, 16'h4321, 3'd0, 1'b0);
    // R2 borrow, equality and overflow
    drive(16'h0000, 16'h0001, 3'd1, 1'b1);
    drive(16'h5555, 16'h5555, 3'd1, 1'b0);
    drive(16'h8000, 16'h0001, 3'd1, 1'b1);
    drive(16'h7FFF, 16'hFFFF, 3'd1, 1'b0);
    // R3 decrement of zero, most negative, one
    drive(16'h0000, 16'hABCD, 3'd2, 1'b1);
    drive(16'h8000, 16'h0000, 3'd2, 1'b0);
    drive(16'h0001, 16'hFFFF, 3'd2, 1'b0);
    // R4, R5 logic codes
    drive(16'hF0F0, 16'hFF00, 3'd3, 1'b1);
    drive(16'h0F0F, 16'h00F0, 3'd4, 1'b0);
    drive(16'hFFFF, 16'h0000, 3'd5, 1'b1);
    drive(16'h00FF, 16'h0000, 3'd5, 1'b0);
    // R6 reserved codes
    drive(16'hFFFF, 16'hFFFF, 3'd6, 1'b1);
    drive(16'hFFFF, 16'h0001, 3'd7, 1'b0);
    // R11 hold over a run of disabled cycles
    repeat (4) drive(16'h8000, 16'h7FFF, 3'd1, 1'b0);
    // Sweep of all codes, R8 under every code
    for (int i = 0; i < 600; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      drive(lf[15:0], lf[31:16], lf[2:0] ^ 3'(i), lf[7]);
    end
    drive('0, '0, 3'd0, 1'b0);
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #2 finish_run();
  end

endmodule